// File: doc/BRIEF.md
# Pointer Address Arithmetic Unit

This unit turns a pointer, an offset and an addressing mode into a 32-bit byte address for the memory side of a 16-bit processor. It keeps four 32-bit pointers: program counter, stack pointer, frame pointer and base pointer. Each pointer is stored as two 16-bit halves, and software can write the halves separately. A single 32-bit carry-lookahead adder adds a sign-extended 16-bit offset to the chosen pointer. The chosen address is registered in a memory address buffer for one access.

There are five addressing modes: immediate, direct, indexed, indexed with pre-increment and indexed with post-increment. The two increment modes write the updated pointer back in the same cycle that the address is latched. Immediate mode reads at the program counter and moves it forward by one word.

On interrupt entry the buffer is loaded with the service routine address instead. This address is built from a 16-bit vector base, an 8-bit vector number placed in byte 1, and a zero low byte. A word access at an odd address is flagged as misaligned, but the address is still latched unchanged.

Top module: `ptr_addr_unit`

## Requirements
- R1: After synchronous reset all four pointers read 0, `mab_addr` is 0, and `mab_valid` and `mab_misalign` are 0.
- R2: A software write with `wr_hi`=1 replaces bits 31:16 of the pointer chosen by `wr_sel`, and with `wr_hi`=0 replaces bits 15:0. The other half is left as it was. `rd_ptr` shows the pointer chosen by `rd_sel` with no clock delay. Pointer codes are 0 program counter, 1 stack, 2 frame, 3 base.
- R3: Immediate mode (`req_mode`=0) latches the program counter as the address and sets the program counter to its old value plus 2, modulo 2^32. The `req_ptr` input is ignored in this mode.
- R4: Direct mode (`req_mode`=1) latches `req_direct` as the address. No pointer changes.
- R5: Indexed mode (`req_mode`=2) latches the chosen pointer plus the sign-extended `req_off`, modulo 2^32. No pointer changes.
- R6: Pre-increment mode (`req_mode`=3) latches the chosen pointer plus the sign-extended offset. The same value is written back to that pointer.
- R7: Post-increment mode (`req_mode`=4) latches the old value of the chosen pointer. The pointer plus the sign-extended offset is written back to that pointer.
- R8: When `irq_enter` is high, `mab_addr` becomes {`vec_base`, `irq_vec`, 8'h00} and `mab_misalign` becomes 0. Any request in the same cycle is dropped and causes no pointer writeback.
- R9: `mab_misalign` is 1 exactly when the latched access is a word access (`req_word`=1) and bit 0 of its address is 1. The address is latched unchanged either way.
- R10: Mode codes 5 to 7 do nothing. `mab_addr` and `mab_misalign` hold, `mab_valid` is 0, and no pointer changes.
- R11: If a mode writeback and a software write target the same pointer in the same cycle, the pointer takes the writeback value. A software write to a different pointer in that cycle still takes effect.
- R12: `mab_valid` is high for one cycle after each accepted request or interrupt entry. At all other times it is low and `mab_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer select for indexed modes |
| req_off | input | 16 | Signed offset |
| req_direct | input | 32 | Direct address from the instruction stream |
| req_word | input | 1 | Access is a 16-bit word |
| wr_en | input | 1 | Software half-pointer write |
| wr_sel | input | 2 | Pointer to write |
| wr_hi | input | 1 | 1 writes the high half, 0 writes the low half |
| wr_data | input | 16 | Half-pointer write data |
| irq_enter | input | 1 | Interrupt entry |
| irq_vec | input | 8 | Vector number |
| vec_base | input | 16 | Vector base (upper address half) |
| rd_sel | input | 2 | Pointer read select |
| rd_ptr | output | 32 | Selected pointer value |
| mab_addr | output | 32 | Memory address buffer |
| mab_valid | output | 1 | Buffer loaded last cycle |
| mab_misalign | output | 1 | Latched word access is at an odd address |

## Verification
The assertions assume that `req_mode` and `irq_enter` are always driven to known values. The check that a pointer stays stable in indexed mode also assumes that no software write happens in the same cycle. The bench keeps software writes and requests in separate cycles for its sweep. The only exceptions are the dedicated collision cases, and those do not use indexed mode. Interrupt entry is only driven together with a request when the bench is checking that the request is dropped.

// File: rtl/pau_pkg.sv
package pau_pkg;

    localparam int HALF_W  = 16;
    localparam int ADDR_W  = 2 * HALF_W;
    localparam int NPTR    = 4;
    localparam int SEL_W   = $clog2(NPTR);
    localparam int MODE_W  = 3;
    localparam int VEC_W   = 8;

    // Pointer codes
    localparam logic [SEL_W-1:0] PTR_PC = 2'd0;
    localparam logic [SEL_W-1:0] PTR_SP = 2'd1;
    localparam logic [SEL_W-1:0] PTR_FP = 2'd2;
    localparam logic [SEL_W-1:0] PTR_BP = 2'd3;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 3'd0,
        AM_DIR  = 3'd1,
        AM_IDX  = 3'd2,
        AM_PRE  = 3'd3,
        AM_POST = 3'd4
    } addr_mode_e;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] val;
    } ptr_wb_t;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  sel;
        logic              hi;
        logic [HALF_W-1:0] data;
    } half_wr_t;

    typedef struct packed {
        logic              load;
        logic [ADDR_W-1:0] addr;
        logic              misalign;
    } mab_next_t;

    function automatic logic [ADDR_W-1:0] sext_off(input logic [HALF_W-1:0] off);
        return {{(ADDR_W-HALF_W){off[HALF_W-1]}}, off};
    endfunction

    function automatic logic [ADDR_W-1:0] isr_addr(input logic [HALF_W-1:0] base,
                                                   input logic [VEC_W-1:0]  vec);
        return {base, vec, {(ADDR_W-HALF_W-VEC_W){1'b0}}};
    endfunction

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        return m <= AM_POST;
    endfunction

endpackage

// File: rtl/pau_cla.sv
module pau_cla #(
    parameter int W     = 32,
    parameter int GRP_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int NGRP = W / GRP_W;

    logic [W-1:0]  gen_b, prop_b;
    logic [NGRP-1:0] grp_g, grp_p;
    logic [NGRP:0]   grp_c;

    assign gen_b  = a & b;
    assign prop_b = a ^ b;

    // Group generate/propagate, one block per nibble group
    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        logic [GRP_W:0] c_in_grp;

        always_comb begin
            logic gg, pp;
            gg = 1'b0;
            pp = 1'b1;
            for (int j = 0; j < GRP_W; j++) begin
                gg = gen_b[gi*GRP_W+j] | (prop_b[gi*GRP_W+j] & gg);
                pp = pp & prop_b[gi*GRP_W+j];
            end
            grp_g[gi] = gg;
            grp_p[gi] = pp;
        end

        // Internal carries from group carry-in (lookahead inside group)
        always_comb begin
            c_in_grp[0] = grp_c[gi];
            for (int j = 0; j < GRP_W; j++) begin
                c_in_grp[j+1] = gen_b[gi*GRP_W+j] | (prop_b[gi*GRP_W+j] & c_in_grp[j]);
            end
        end

        assign sum[gi*GRP_W +: GRP_W] = prop_b[gi*GRP_W +: GRP_W] ^ c_in_grp[GRP_W-1:0];
    end

    // Second level: group carries
    always_comb begin
        grp_c[0] = 1'b0;
        for (int k = 0; k < NGRP; k++) begin
            grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
        end
    end

endmodule

// File: rtl/pau_ptr_bank.sv
module pau_ptr_bank
    import pau_pkg::*;
#(
    parameter int N  = NPTR,
    parameter int HW = HALF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  half_wr_t           sw_wr,
    input  ptr_wb_t            wb,
    output logic [N*2*HW-1:0]  ptr_flat
);
    for (genvar pi = 0; pi < N; pi++) begin : g_ptr
        logic [HW-1:0] hi_q, lo_q;
        logic wb_hit, sw_hit;

        assign wb_hit = wb.en && (wb.sel == SEL_W'(pi));
        assign sw_hit = sw_wr.en && (sw_wr.sel == SEL_W'(pi));

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wb_hit) begin
                hi_q <= wb.val[2*HW-1:HW];
                lo_q <= wb.val[HW-1:0];
            end else if (sw_hit) begin
                if (sw_wr.hi) hi_q <= sw_wr.data;
                else          lo_q <= sw_wr.data;
            end
        end

        assign ptr_flat[pi*2*HW +: 2*HW] = {hi_q, lo_q};
    end

endmodule

// File: rtl/pau_mode_ctl.sv
module pau_mode_ctl
    import pau_pkg::*;
(
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [SEL_W-1:0]  req_ptr,
    input  logic [HALF_W-1:0] req_off,
    input  logic [ADDR_W-1:0] req_direct,
    input  logic              req_word,
    input  logic              irq_enter,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [HALF_W-1:0] vec_base,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [ADDR_W-1:0] sel_val,
    output logic [ADDR_W-1:0] add_a,
    output logic [ADDR_W-1:0] add_b,
    input  logic [ADDR_W-1:0] add_sum,
    output ptr_wb_t           wb,
    output mab_next_t         nxt
);
    logic accept;
    logic [ADDR_W-1:0] eff;

    assign accept = req_valid && !irq_enter && mode_known(req_mode);

    always_comb begin
        add_a = sel_val;
        add_b = sext_off(req_off);
        if (req_mode == AM_IMM) begin
            add_a = pc_val;
            add_b = ADDR_W'(2);
        end
    end

    always_comb begin
        wb  = '0;
        eff = add_sum;
        case (req_mode)
            AM_IMM: begin
                eff    = pc_val;
                wb.en  = accept;
                wb.sel = PTR_PC;
                wb.val = add_sum;
            end
            AM_DIR: eff = req_direct;
            AM_IDX: eff = add_sum;
            AM_PRE: begin
                eff    = add_sum;
                wb.en  = accept;
                wb.sel = req_ptr;
                wb.val = add_sum;
            end
            AM_POST: begin
                eff    = sel_val;
                wb.en  = accept;
                wb.sel = req_ptr;
                wb.val = add_sum;
            end
            default: eff = add_sum;
        endcase
    end

    always_comb begin
        nxt = '0;
        if (irq_enter) begin
            nxt.load     = 1'b1;
            nxt.addr     = isr_addr(vec_base, irq_vec);
            nxt.misalign = 1'b0;
        end else if (accept) begin
            nxt.load     = 1'b1;
            nxt.addr     = eff;
            nxt.misalign = req_word && eff[0];
        end
    end

endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import pau_pkg::*;
#(
    parameter int CLA_GRP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [SEL_W-1:0]  req_ptr,
    input  logic [HALF_W-1:0] req_off,
    input  logic [ADDR_W-1:0] req_direct,
    input  logic              req_word,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              irq_enter,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [HALF_W-1:0] vec_base,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] mab_addr,
    output logic              mab_valid,
    output logic              mab_misalign
);
    logic [NPTR*ADDR_W-1:0] ptr_flat;
    logic [ADDR_W-1:0]      sel_ptr, pc_ptr, add_a, add_b, add_sum;
    half_wr_t               sw_wr;
    ptr_wb_t                wb;
    mab_next_t              nxt;

    assign sw_wr = '{en: wr_en, sel: wr_sel, hi: wr_hi, data: wr_data};

    pau_ptr_bank #(.N(NPTR), .HW(HALF_W)) bank_i (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .wb(wb), .ptr_flat(ptr_flat)
    );

    assign sel_ptr = ptr_flat[req_ptr*ADDR_W +: ADDR_W];
    assign pc_ptr  = ptr_flat[PTR_PC*ADDR_W +: ADDR_W];
    assign rd_ptr  = ptr_flat[rd_sel*ADDR_W +: ADDR_W];

    pau_mode_ctl ctl_i (
        .req_valid(req_valid), .req_mode(req_mode), .req_ptr(req_ptr),
        .req_off(req_off), .req_direct(req_direct), .req_word(req_word),
        .irq_enter(irq_enter), .irq_vec(irq_vec), .vec_base(vec_base),
        .pc_val(pc_ptr), .sel_val(sel_ptr),
        .add_a(add_a), .add_b(add_b), .add_sum(add_sum),
        .wb(wb), .nxt(nxt)
    );

    pau_cla #(.W(ADDR_W), .GRP_W(CLA_GRP)) cla_i (
        .a(add_a), .b(add_b), .sum(add_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mab_addr     <= '0;
            mab_valid    <= 1'b0;
            mab_misalign <= 1'b0;
        end else begin
            mab_valid <= nxt.load;
            if (nxt.load) begin
                mab_addr     <= nxt.addr;
                mab_misalign <= nxt.misalign;
            end
        end
    end

endmodule

// File: rtl/pau_chk.sv
module pau_chk
    import pau_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [MODE_W-1:0]      req_mode,
    input logic [ADDR_W-1:0]      req_direct,
    input logic                   wr_en,
    input logic                   irq_enter,
    input logic [VEC_W-1:0]       irq_vec,
    input logic [HALF_W-1:0]      vec_base,
    input logic [ADDR_W-1:0]      mab_addr,
    input logic                   mab_valid,
    input logic                   mab_misalign,
    input logic [NPTR*ADDR_W-1:0] ptr_flat,
    input logic [ADDR_W-1:0]      sel_ptr
);
    a_r9_misalign_odd: assert property (@(posedge clk) disable iff (rst)
        mab_misalign |-> mab_addr[0]);

    a_r8_isr_addr: assert property (@(posedge clk) disable iff (rst)
        irq_enter |=> (mab_addr == {$past(vec_base), $past(irq_vec), 8'h00}) && !mab_misalign);

    a_r4_direct: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !irq_enter && req_mode == 3'd1) |=> mab_addr == $past(req_direct));

    a_r5_idx_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !irq_enter && !wr_en && req_mode == 3'd2) |=> $stable(ptr_flat));

    a_r7_post_old_ptr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !irq_enter && req_mode == 3'd4) |=> mab_addr == $past(sel_ptr));

    a_r10_bad_mode: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !irq_enter && req_mode > 3'd4) |=> !mab_valid && $stable(mab_addr));

    a_r12_no_req_no_valid: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !irq_enter) |=> !mab_valid && $stable(mab_addr));
endmodule

bind ptr_addr_unit pau_chk chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_direct(req_direct), .wr_en(wr_en), .irq_enter(irq_enter),
    .irq_vec(irq_vec), .vec_base(vec_base), .mab_addr(mab_addr),
    .mab_valid(mab_valid), .mab_misalign(mab_misalign),
    .ptr_flat(ptr_flat), .sel_ptr(sel_ptr)
);

// File: tb/ptr_addr_unit_tb_top.sv
`timescale 1ns/1ps
module ptr_addr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_word, wr_en, wr_hi, irq_enter;
    logic [2:0]  req_mode;
    logic [1:0]  req_ptr, wr_sel, rd_sel;
    logic [15:0] req_off, wr_data, vec_base;
    logic [31:0] req_direct, rd_ptr, mab_addr;
    logic [7:0]  irq_vec;
    logic        mab_valid, mab_misalign;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_ptr [4];
    logic [31:0] e_addr;
    logic        e_mis;

    always #2.5 clk = ~clk;

    ptr_addr_unit dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ptrs(input string req);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #0.1;
            chk(req, rd_ptr, m_ptr[i]);
        end
    endtask

    task automatic idle();
        req_valid = 0; wr_en = 0; irq_enter = 0;
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic hi, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_hi = hi; wr_data = d;
        @(posedge clk); @(negedge clk);
        idle();
        if (hi) m_ptr[sel][31:16] = d; else m_ptr[sel][15:0] = d;
    endtask

    task automatic load_ptr(input logic [1:0] sel, input logic [31:0] v);
        sw_write(sel, 1'b1, v[31:16]);
        sw_write(sel, 1'b0, v[15:0]);
        rd_sel = sel; #0.1;
        chk("R2 half write", rd_ptr, v);
    endtask

    task automatic do_req(input logic [2:0] mode, input logic [1:0] sel,
                          input logic [15:0] off, input logic [31:0] dir, input logic word);
        logic [31:0] so, sum, a;
        logic        ok;
        string       tag;
        so = {{16{off[15]}}, off};
        sum = m_ptr[sel] + so;
        ok = 1;
        case (mode)
            3'd0: begin a = m_ptr[0]; m_ptr[0] = m_ptr[0] + 32'd2; tag = "R3 immediate"; end
            3'd1: begin a = dir; tag = "R4 direct"; end
            3'd2: begin a = sum; tag = "R5 indexed"; end
            3'd3: begin a = sum; m_ptr[sel] = sum; tag = "R6 pre-inc"; end
            3'd4: begin a = m_ptr[sel]; m_ptr[sel] = sum; tag = "R7 post-inc"; end
            default: begin a = e_addr; ok = 0; tag = "R10 bad mode"; end
        endcase
        if (ok) begin e_addr = a; e_mis = word & a[0]; end
        req_valid = 1; req_mode = mode; req_ptr = sel; req_off = off;
        req_direct = dir; req_word = word;
        @(posedge clk); @(negedge clk);
        idle();
        chk(tag, mab_addr, e_addr);
        chk(ok ? "R12 valid pulse" : "R10 no valid", {31'd0, mab_valid}, {31'd0, ok});
        chk("R9 misalign", {31'd0, mab_misalign}, {31'd0, e_mis});
        chk_ptrs(tag);
        @(posedge clk); @(negedge clk);
        chk("R12 valid drops", {31'd0, mab_valid}, 32'd0);
        chk("R12 addr holds", mab_addr, e_addr);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] bases [5];
        logic [15:0] offs [7];
        bases = '{32'h0000_0000, 32'h0000_FFFE, 32'h1234_5679, 32'hFFFF_FFFF, 32'h7FFF_8000};
        offs  = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFE, 16'h7FFF, 16'h8000, 16'hFFFF};
        idle();
        req_mode = 0; req_ptr = 0; req_off = 0; req_direct = 0; req_word = 0;
        wr_sel = 0; wr_hi = 0; wr_data = 0; irq_vec = 0; vec_base = 0; rd_sel = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        for (int i = 0; i < 4; i++) m_ptr[i] = 0;
        e_addr = 0; e_mis = 0;
        // R1 reset state
        chk("R1 mab_addr", mab_addr, 0);
        chk("R1 mab_valid", {31'd0, mab_valid}, 0);
        chk("R1 misalign", {31'd0, mab_misalign}, 0);
        chk_ptrs("R1 pointers");

        // R2 independent halves
        sw_write(2'd2, 1'b1, 16'hABCD);
        chk_ptrs("R2 hi only");
        sw_write(2'd2, 1'b0, 16'h1357);
        chk_ptrs("R2 lo only");

        // Sweep modes x pointers x bases x offsets
        for (int b = 0; b < 5; b++)
            for (int o = 0; o < 7; o++)
                for (int m = 0; m < 8; m++)
                    for (int p = 0; p < 4; p++) begin
                        load_ptr(2'(p), bases[b]);
                        do_req(3'(m), 2'(p), offs[o], bases[b] ^ {16'h5A5A, offs[o]},
                               1'((m + p + o) & 1));
                    end

        // R8 interrupt entry overrides a post-inc request
        for (int v = 0; v < 256; v += 37) begin
            load_ptr(2'd1, 32'h0000_1001);
            vec_base = 16'(v * 911);
            irq_vec = 8'(v);
            irq_enter = 1; req_valid = 1; req_mode = 3'd4; req_ptr = 2'd1;
            req_off = 16'h0010; req_word = 1;
            @(posedge clk); @(negedge clk);
            idle();
            e_addr = {vec_base, irq_vec, 8'h00}; e_mis = 0;
            chk("R8 isr address", mab_addr, e_addr);
            chk("R8 valid", {31'd0, mab_valid}, 1);
            chk("R8 no misalign", {31'd0, mab_misalign}, 0);
            chk_ptrs("R8 request dropped");
        end

        // R11 collision: pre-inc writeback wins on same pointer
        load_ptr(2'd1, 32'h0000_2000);
        wr_en = 1; wr_sel = 2'd1; wr_hi = 0; wr_data = 16'hDEAD;
        do_req(3'd3, 2'd1, 16'h0004, 32'd0, 1'b1);
        chk("R11 wb wins", m_ptr[1], 32'h0000_2004);
        // R11 other pointer still written
        load_ptr(2'd3, 32'h0000_0100);
        wr_en = 1; wr_sel = 2'd2; wr_hi = 1; wr_data = 16'hBEEF;
        m_ptr[2][31:16] = 16'hBEEF;
        do_req(3'd4, 2'd3, 16'hFFFE, 32'd0, 1'b0);
        chk("R11 other ptr", m_ptr[3], 32'h0000_00FE);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule